// File: doc/BRIEF.md
# Nine-Bit Three-Wire Display Serializer

This block sends command and data bytes to a small display controller that has no separate data/command pin. Each incoming byte is turned into a 9-bit word. The leading bit of the word says whether the byte is a command or data, and the eight payload bits follow. The words are packed back to back into one serial bit stream and shifted out on a clock line and a data line in SPI mode 0. Chip select stays asserted for the whole message.

A controller cannot accept a partial byte at the end of a select window. When the last word of a message leaves the stream short of a byte boundary, the block appends whole 9-bit command words carrying a padding opcode until the bit count is a multiple of eight. The padding opcode is a runtime input. Use either a no-operation opcode or a memory-write opcode that is harmless to repeat.

The host presents bytes on a valid/ready interface. Each byte carries a command/data tag, and an end-of-message marker is raised on the final byte. In a command message the first byte is tagged command and its 0 to 15 parameter bytes are tagged data. The host is free to tag bytes in other ways.

Top module: `nine_bit_spi_ser`

## Requirements
- R1: Each byte is sent as one 9-bit word: the flag bit first, then the eight payload bits, most significant bit first.
- R2: The flag bit is 0 for a byte accepted with `in_is_data` low (command) and 1 for a byte accepted with `in_is_data` high (data).
- R3: Words follow each other with no missing or extra bits. For a message of N bytes followed by P padding words, exactly 9*(N+P) rising clock edges occur while `cs_n` is low.
- R4: After the last word (`in_last` high), the block adds P = (8 - N mod 8) mod 8 padding words. Each padding word is {0, `pad_op`}, with `pad_op` taken when that word starts. The total bit count at release of `cs_n` is therefore a multiple of 8.
- R5: `sclk` is low whenever `cs_n` is high. `mosi` never changes while `sclk` is high, so it changes only while `sclk` is low (SPI mode 0).
- R6: Every high phase of `sclk` lasts exactly HALF system clocks. Every low phase inside a message lasts at least HALF system clocks, so the default HALF=7 at 125 MHz gives a bit period of at least 100 ns.
- R7: `cs_n` falls at least HALF clocks before the first rising edge of `sclk`. It rises only after `sclk` has been low for at least HALF clocks following the final bit. It then stays high for at least 2*HALF clocks before the next message.
- R8: After reset, `cs_n`=1, `sclk`=0, `busy`=0 and `in_ready`=1. `in_ready` is high only while idle or between words of a message, never while `sclk` is high. `busy` is high whenever `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| in_byte | input | 8 | Payload byte |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_last | input | 1 | Marks the final byte of a message |
| pad_op | input | 8 | Opcode used for padding words |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | High from the first accepted byte until the post-message gap ends |

## Verification
The assertions assume two things about the inputs:
- `in_byte`, `in_is_data` and `in_last` are meaningful only on a handshake.
- `pad_op` holds steady while a message's padding is being sent.

The checks on phase length and alignment also assume that the host eventually ends every message with `in_last`. The stimulus meets these assumptions in three ways:
- It sweeps message lengths 1 to 16 in command-message, all-data and all-command forms.
- It holds `pad_op` fixed for each message, alternating between two opcodes from one message to the next.
- It offers each new message as soon as the block is ready again, which exercises the minimum gap between messages.

// File: rtl/nine_bit_spi_ser.sv
module nine_bit_spi_ser #(
  parameter int HALF = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_is_data,
  input  logic       in_last,
  input  logic [7:0] pad_op,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n,
  output logic       busy
);
  localparam int TW = $clog2(2 * HALF + 1);
  localparam logic [TW-1:0] T_HALF = TW'(HALF - 1);
  localparam logic [TW-1:0] T_GAP  = TW'(2 * HALF - 1);

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_WAIT, S_TAIL, S_GAP} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [8:0]    sh;
  logic [3:0]    bidx;
  logic [2:0]    mod8;
  logic          last_q;
  logic          sclk_q;
  logic          cs_q;

  assign in_ready = (st == S_IDLE) || (st == S_WAIT);
  assign busy     = (st != S_IDLE);
  assign sclk     = sclk_q;
  assign cs_n     = cs_q;
  assign mosi     = sh[8];

  wire take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      sh     <= '0;
      bidx   <= '0;
      mod8   <= '0;
      last_q <= 1'b0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      case (st)
        S_IDLE, S_WAIT: begin
          if (take) begin
            sh     <= {in_is_data, in_byte};
            last_q <= in_last;
            bidx   <= '0;
            tmr    <= '0;
            cs_q   <= 1'b0;
            st     <= S_LO;
          end
        end
        S_LO: begin
          if (tmr == T_HALF) begin
            tmr    <= '0;
            sclk_q <= 1'b1;
            st     <= S_HI;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_HI: begin
          if (tmr == T_HALF) begin
            tmr    <= '0;
            sclk_q <= 1'b0;
            mod8   <= mod8 + 3'd1;
            if (bidx != 4'd8) begin
              sh   <= {sh[7:0], 1'b0};
              bidx <= bidx + 4'd1;
              st   <= S_LO;
            end else if (!last_q) begin
              st <= S_WAIT;
            end else if (mod8 == 3'd7) begin
              st <= S_TAIL;
            end else begin
              sh   <= {1'b0, pad_op};
              bidx <= '0;
              st   <= S_LO;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_TAIL: begin
          if (tmr == T_HALF) begin
            tmr  <= '0;
            cs_q <= 1'b1;
            st   <= S_GAP;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_GAP: begin
          if (tmr == T_GAP) begin
            tmr <= '0;
            st  <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [TW-1:0] chk_hi;
  always_ff @(posedge clk) begin
    if (!rst_n) chk_hi <= '0;
    else        chk_hi <= sclk ? chk_hi + 1'b1 : '0;
  end

  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  assert_mosi_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  assert_hi_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (chk_hi == TW'(HALF)));
  assert_hi_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (chk_hi < TW'(HALF)));
  assert_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (mod8 == 3'd0));
  assert_cs_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sclk && $past(!sclk)));
  assert_ready_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !in_ready);
  assert_busy_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
endmodule

// File: tb/sim_nine_bit_spi_ser.sv
module sim_nine_bit_spi_ser;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_byte = '0;
  logic in_is_data = 1'b0;
  logic in_last = 1'b0;
  logic [7:0] pad_op = '0;
  logic sclk, mosi, cs_n, busy;

  always #4 clk = ~clk;

  nine_bit_spi_ser #(.HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data), .in_last(in_last),
    .pad_op(pad_op), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic cap [0:255];
  int nbits = 0;
  logic prev_sclk = 1'b0;
  logic prev_cs = 1'b1;
  int hi_run = 0, lo_run = 0, gap_run = 0;
  bit seen_msg = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && prev_cs) begin
        nbits = 0;
        if (seen_msg) check(gap_run >= 2 * HALF, "R7 gap", gap_run, 2 * HALF);
        seen_msg = 1;
      end
      if (cs_n) gap_run++; else gap_run = 0;
      if (cs_n && sclk) check(0, "R5 idle sclk", 1, 0);
      if (sclk && in_ready) check(0, "R8 ready while sclk high", 1, 0);
      if (!cs_n && !busy) check(0, "R8 busy during cs", 0, 1);
      if (sclk && !prev_sclk && !cs_n) begin
        check(lo_run >= HALF, "R6/R7 low phase", lo_run, HALF);
        if (nbits < 256) cap[nbits] = mosi;
        nbits++;
      end
      if (!sclk && prev_sclk) check(hi_run == HALF, "R6 high phase", hi_run, HALF);
      if (cs_n && !prev_cs) check(lo_run >= HALF, "R7 tail", lo_run, HALF);
      if (sclk) begin hi_run++; lo_run = 0; end
      else begin hi_run = 0; if (!cs_n) lo_run++; end
      prev_sclk = sclk;
      prev_cs = cs_n;
    end
  end

  logic [8:0] exp_w [0:23];

  task automatic send_msg(input int n, input int kind, input logic [7:0] pad);
    int p;
    p = (8 - (n % 8)) % 8;
    pad_op = pad;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      logic d;
      b = 8'((n * 37 + i * 11 + kind * 101) & 255);
      d = (kind == 0) ? (i != 0) : (kind == 1);
      exp_w[i] = {d, b};
      @(negedge clk);
      in_valid = 1'b1; in_byte = b; in_is_data = d; in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
    end
    for (int j = 0; j < p; j++) exp_w[n + j] = {1'b0, pad};
    @(negedge clk);
    while (busy) @(negedge clk);
    check(nbits == 9 * (n + p), "R3 bit count", nbits, 9 * (n + p));
    check((nbits % 8) == 0, "R4 byte aligned", nbits % 8, 0);
    for (int w = 0; w < n + p; w++) begin
      logic [8:0] got;
      for (int k = 0; k < 9; k++) got[8 - k] = cap[w * 9 + k];
      if (w < n) begin
        check(got[8] == exp_w[w][8], "R2 flag", got[8], exp_w[w][8]);
        check(got[7:0] == exp_w[w][7:0], "R1 payload", got[7:0], exp_w[w][7:0]);
      end else begin
        check(got == exp_w[w], "R4 pad word", got, exp_w[w]);
      end
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n == 1'b1, "R8 reset cs_n", cs_n, 1);
    check(sclk == 1'b0, "R8 reset sclk", sclk, 0);
    check(busy == 1'b0, "R8 reset busy", busy, 0);
    check(in_ready == 1'b1, "R8 reset in_ready", in_ready, 1);
    for (int n = 1; n <= 16; n++)
      for (int kind = 0; kind < 3; kind++)
        send_msg(n, kind, ((n + kind) % 2) ? 8'hE3 : 8'h5C);
    finish_run();
  end
endmodule